// File: doc/BRIEF.md
# LPC I/O Cycle Master with Register Staging

This block lets a processor run Low Pin Count bus I/O reads and writes through a small memory-mapped register file. Software first checks that the block is idle. It then programs a command word, a byte count and a 16-bit target address. For a write it pushes the outgoing bytes one at a time into a data port. Setting the launch bit starts the transfer.

The block runs one complete LPC I/O cycle per byte on the LAD nibble bus and the frame strobe. It walks the address forward or holds it fixed, as the command asks. Returned read bytes go into a read buffer, and software drains that buffer through a single read port.

When the transfer ends, an interrupt status bit sets and drives the interrupt pin. Software clears it by writing one to it. A separate finished flag in the status register tells a good transfer from one that was aborted. An abort happens on a peripheral error SYNC, or when the SYNC phase lasts too long.

Top module: `lpc_io_master`

## Requirements
- R1: After reset the status register (offset 0x04) reads 1: bit 0, idle, is 1 and bit 1, finished, is 0. The interrupt register (0x08) reads 0, `irq` is low, `lframe_n` is high and `lad_oe` is low.
- R2: Each write byte is one bus frame, one nibble per clock. The frame is: start nibble 0000 with `lframe_n` low, then direction nibble 0010, then the four address nibbles with bits [15:12] first, then the data byte with the low nibble first.
- R3: Each read byte sends direction nibble 0000 and the four address nibbles. After SYNC ready, the byte is taken from two LAD nibbles, low nibble first. Successive reads of offset 0x28 return the bytes in bus order, and 0 once the buffer is empty.
- R4: During SYNC, the codes 0101 and 0110 hold the cycle in wait. The code 0000 lets the cycle go on, and the transfer completes normally.
- R5: Command bit 3 selects the address mode. When it is 0, the address rises by one for each byte of the transfer. When it is 1, every byte uses the programmed address.
- R6: When all bytes are done, bit 1 of the interrupt register and `irq` go high, and status reads 3. Writing 1 to bit 1 of offset 0x08 clears the interrupt.
- R7: A SYNC code of 1010 ends the transfer. No further frame is started, `irq` rises and status reads 1, with finished clear.
- R8: If the SYNC phase passes `SYNC_TMO` clocks with neither ready nor error, the transfer is aborted in the same way as in R7.
- R9: While a transfer is running, writes to the command (0x14), length (0x10), address (0x20) and write-data (0x24) offsets have no effect. A launch written at that time is ignored as well.
- R10: Launching with a length of 0 does nothing. No frame starts, `irq` stays low and the status stays as it was.
- R11: Command bits [2:1] give the cycle type, and only 00 (I/O) runs. A launch with any other type starts no frame, raises `irq` and leaves status at 1.
- R12: Status bit 0 reads 0 for the whole of a transfer. `lframe_n` and `lad_oe` are active only while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the LPC bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of offset 0x28 pops one byte |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the read strobe |
| irq | output | 1 | Transfer-end interrupt, equal to interrupt register bit 1 |
| lframe_n | output | 1 | Frame strobe, active low during the start nibble |
| lad_out | output | 4 | LAD value driven by the block |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| lad_in | input | 4 | LAD value returned by the peripheral |

## Verification
A wrong sequencer state shows up on the LAD bus within one clock. It appears as a misplaced or wrong nibble in the frame the peripheral model decodes, for example a wrong direction code, address nibble order or data nibble order. A wrong byte count or a wrong address step shows up as an extra frame, a missing frame or a wrong captured address by the end of the transfer. A lost abort or a lost completion shows up at `irq` and in the status register within a few clocks of the final SYNC. Wrong buffer pointers show up as bytes out of order, or as stale bytes, on the next drain of the read port or in the next write frame.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

  // Register byte offsets (software visible)
  localparam logic [7:0] OFS_GO   = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_INT  = 8'h08;
  localparam logic [7:0] OFS_LEN  = 8'h10;
  localparam logic [7:0] OFS_CMD  = 8'h14;
  localparam logic [7:0] OFS_ADR  = 8'h20;
  localparam logic [7:0] OFS_WDAT = 8'h24;
  localparam logic [7:0] OFS_RDAT = 8'h28;

  // Bus nibble codes
  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_IO_WR  = 4'h2;
  localparam logic [3:0] NIB_IO_RD  = 4'h0;
  localparam logic [3:0] NIB_IDLE   = 4'hF;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_FAULT = 4'hA;

  localparam int IO_ADDR_W = 16;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CT, PH_A3, PH_A2, PH_A1, PH_A0,
    PH_WD0, PH_WD1, PH_TA0, PH_TA1, PH_SYNC,
    PH_RD0, PH_RD1, PH_TB0, PH_TB1
  } phase_t;

  typedef enum logic [1:0] {CT_IDLE, CT_ISSUE, CT_WAIT} ctl_t;

  // Command word, bit 0 = write, [2:1] = cycle type, 3 = fixed address
  typedef struct packed {
    logic       fixed_adr;
    logic [1:0] kind;
    logic       wr;
  } cmd_t;

endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_nx, rp_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp_q];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_nx  = wp_q;
    rp_nx  = rp_q;
    cnt_nx = cnt_q;
    if (flush) begin
      wp_nx  = '0;
      rp_nx  = '0;
      cnt_nx = '0;
    end else begin
      if (do_push) wp_nx = step(wp_q);
      if (do_pop)  rp_nx = step(rp_q);
      if (do_push && !do_pop) cnt_nx = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= din;
  end

endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_io_pkg::*;
#(
  parameter int SYNC_TMO = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 wr,
  input  logic [IO_ADDR_W-1:0] io_addr,
  input  logic [7:0]           wbyte,
  input  logic [3:0]           lad_in,
  output logic                 lframe_n,
  output logic [3:0]           lad_out,
  output logic                 lad_oe,
  output logic                 done,
  output logic                 fail,
  output logic [7:0]           rbyte
);
  localparam int TW = $clog2(SYNC_TMO + 1);

  phase_t               ph_q, ph_nx;
  logic [IO_ADDR_W-1:0] a_q;
  logic [7:0]           w_q, r_q, r_nx;
  logic                 wr_q, ld;
  logic [TW-1:0]        t_q, t_nx;
  logic                 done_nx, fail_nx;

  // Next-state logic
  always_comb begin
    ph_nx   = ph_q;
    t_nx    = t_q;
    r_nx    = r_q;
    done_nx = 1'b0;
    fail_nx = 1'b0;
    ld      = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (go) begin ph_nx = PH_START; ld = 1'b1; end
      PH_START: ph_nx = PH_CT;
      PH_CT:    ph_nx = PH_A3;
      PH_A3:    ph_nx = PH_A2;
      PH_A2:    ph_nx = PH_A1;
      PH_A1:    ph_nx = PH_A0;
      PH_A0:    ph_nx = wr_q ? PH_WD0 : PH_TA0;
      PH_WD0:   ph_nx = PH_WD1;
      PH_WD1:   ph_nx = PH_TA0;
      PH_TA0:   ph_nx = PH_TA1;
      PH_TA1: begin ph_nx = PH_SYNC; t_nx = '0; end
      PH_SYNC: begin
        if (lad_in == SYNC_READY) begin
          ph_nx = wr_q ? PH_TB0 : PH_RD0;
        end else if (lad_in == SYNC_FAULT || t_q == TW'(SYNC_TMO - 1)) begin
          ph_nx   = PH_IDLE;
          done_nx = 1'b1;
          fail_nx = 1'b1;
        end else begin
          t_nx = t_q + 1'b1;
        end
      end
      PH_RD0: begin r_nx[3:0] = lad_in; ph_nx = PH_RD1; end
      PH_RD1: begin r_nx[7:4] = lad_in; ph_nx = PH_TB0; end
      PH_TB0:   ph_nx = PH_TB1;
      PH_TB1: begin ph_nx = PH_IDLE; done_nx = 1'b1; end
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      t_q  <= '0;
      r_q  <= '0;
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      ph_q <= ph_nx;
      t_q  <= t_nx;
      r_q  <= r_nx;
      done <= done_nx;
      fail <= fail_nx;
    end
  end

  // Per-byte operands, loaded only on launch
  always_ff @(posedge clk) begin
    if (ld) begin
      a_q  <= io_addr;
      w_q  <= wbyte;
      wr_q <= wr;
    end
  end

  // Pin decode from the phase register
  always_comb begin
    lframe_n = 1'b1;
    lad_oe   = 1'b1;
    lad_out  = NIB_IDLE;
    unique case (ph_q)
      PH_START: begin lframe_n = 1'b0; lad_out = NIB_START; end
      PH_CT:    lad_out = wr_q ? NIB_IO_WR : NIB_IO_RD;
      PH_A3:    lad_out = a_q[15:12];
      PH_A2:    lad_out = a_q[11:8];
      PH_A1:    lad_out = a_q[7:4];
      PH_A0:    lad_out = a_q[3:0];
      PH_WD0:   lad_out = w_q[3:0];
      PH_WD1:   lad_out = w_q[7:4];
      PH_TA0:   lad_out = NIB_IDLE;
      default:  lad_oe  = 1'b0;
    endcase
  end

  assign rbyte = r_q;

endmodule

// File: rtl/lpc_io_master.sv
module lpc_io_master
  import lpc_io_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 8,
  parameter int SYNC_TMO   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        lframe_n,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  input  logic [3:0]  lad_in
);
  localparam int AW = IO_ADDR_W;

  // Reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ctl_t             cs_q, cs_nx;
  cmd_t             cmd_q;
  logic [LEN_W-1:0] len_q, rem_q, rem_nx;
  logic [AW-1:0]    adr_q, cur_q, cur_nx;
  logic             irq_q, irq_nx, ok_q, ok_nx;
  logic             busy;

  logic             hit_go, cfg_en, cmd_we, len_we, adr_we;
  logic             wf_push, wf_pop, wf_flush, wf_empty, wf_full;
  logic             rf_push, rf_pop, rf_flush, rf_empty, rf_full;
  logic [7:0]       wf_dout, rf_dout;
  logic             seq_go, seq_done, seq_fail;
  logic [7:0]       seq_rbyte;

  assign busy    = (cs_q != CT_IDLE);
  assign hit_go  = reg_wr && (reg_addr == OFS_GO) && reg_wdata[0];
  assign cfg_en  = reg_wr && !busy;
  assign cmd_we  = cfg_en && (reg_addr == OFS_CMD);
  assign len_we  = cfg_en && (reg_addr == OFS_LEN);
  assign adr_we  = cfg_en && (reg_addr == OFS_ADR);
  assign wf_push = cfg_en && (reg_addr == OFS_WDAT);
  assign rf_pop  = reg_rd && (reg_addr == OFS_RDAT);

  // Transfer controller: next state
  always_comb begin
    cs_nx    = cs_q;
    rem_nx   = rem_q;
    cur_nx   = cur_q;
    irq_nx   = irq_q;
    ok_nx    = ok_q;
    seq_go   = 1'b0;
    wf_pop   = 1'b0;
    wf_flush = 1'b0;
    rf_flush = 1'b0;
    rf_push  = 1'b0;
    if (reg_wr && (reg_addr == OFS_INT) && reg_wdata[1]) irq_nx = 1'b0;
    unique case (cs_q)
      CT_IDLE: begin
        if (hit_go && (len_q != '0)) begin
          if (cmd_q.kind != 2'b00) begin
            irq_nx = 1'b1;
            ok_nx  = 1'b0;
          end else begin
            cs_nx    = CT_ISSUE;
            rem_nx   = len_q;
            cur_nx   = adr_q;
            ok_nx    = 1'b0;
            rf_flush = !cmd_q.wr;
          end
        end
      end
      CT_ISSUE: begin
        seq_go = 1'b1;
        wf_pop = cmd_q.wr;
        cs_nx  = CT_WAIT;
      end
      CT_WAIT: begin
        if (seq_done) begin
          if (seq_fail) begin
            cs_nx    = CT_IDLE;
            irq_nx   = 1'b1;
            ok_nx    = 1'b0;
            wf_flush = 1'b1;
          end else begin
            rf_push = !cmd_q.wr;
            if (rem_q == LEN_W'(1)) begin
              cs_nx    = CT_IDLE;
              irq_nx   = 1'b1;
              ok_nx    = 1'b1;
              wf_flush = 1'b1;
            end else begin
              rem_nx = rem_q - 1'b1;
              cur_nx = cur_q + AW'(!cmd_q.fixed_adr);
              cs_nx  = CT_ISSUE;
            end
          end
        end
      end
      default: cs_nx = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cs_q  <= CT_IDLE;
      rem_q <= '0;
      cur_q <= '0;
      irq_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      cs_q  <= cs_nx;
      rem_q <= rem_nx;
      cur_q <= cur_nx;
      irq_q <= irq_nx;
      ok_q  <= ok_nx;
    end
  end

  // Configuration registers, enabled only while idle
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q <= '0;
      len_q <= '0;
      adr_q <= '0;
    end else begin
      if (cmd_we) cmd_q <= cmd_t'(reg_wdata[3:0]);
      if (len_we) len_q <= reg_wdata[LEN_W-1:0];
      if (adr_we) adr_q <= reg_wdata[AW-1:0];
    end
  end

  // Register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_STAT: reg_rdata = {30'd0, ok_q, !busy};
        OFS_INT:  reg_rdata = {30'd0, irq_q, 1'b0};
        OFS_LEN:  reg_rdata = 32'(len_q);
        OFS_CMD:  reg_rdata = 32'(cmd_q);
        OFS_ADR:  reg_rdata = 32'(adr_q);
        OFS_RDAT: reg_rdata = 32'(rf_dout);
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign irq = irq_q;

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_wbuf (
    .clk(clk), .rst_n(rst_i_n), .push(wf_push), .din(reg_wdata[7:0]),
    .pop(wf_pop), .flush(wf_flush), .dout(wf_dout),
    .empty(wf_empty), .full(wf_full)
  );

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rbuf (
    .clk(clk), .rst_n(rst_i_n), .push(rf_push), .din(seq_rbyte),
    .pop(rf_pop), .flush(rf_flush), .dout(rf_dout),
    .empty(rf_empty), .full(rf_full)
  );

  lpc_cycle_seq #(.SYNC_TMO(SYNC_TMO)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .go(seq_go), .wr(cmd_q.wr),
    .io_addr(cur_q), .wbyte(wf_dout), .lad_in(lad_in),
    .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .done(seq_done), .fail(seq_fail), .rbyte(seq_rbyte)
  );

endmodule

// File: rtl/lpc_io_master_chk.sv
module lpc_io_master_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lframe_n,
  input logic [3:0]       lad_out,
  input logic             lad_oe,
  input logic             irq,
  input logic             busy,
  input logic [3:0]       cmd_q,
  input logic [LEN_W-1:0] len_q,
  input logic [15:0]      adr_q
);

  // R2
  frame_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> (lframe_n && lad_oe && (lad_out == 4'h2 || lad_out == 4'h0)));

  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lframe_n && !lad_oe));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(len_q) && $stable(adr_q)));

  // R6
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);

  // R11
  kind_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (cmd_q[2:1] == 2'b00));

endmodule

bind lpc_io_master lpc_io_master_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_out(lad_out),
  .lad_oe(lad_oe), .irq(irq), .busy(busy), .cmd_q(cmd_q),
  .len_q(len_q), .adr_q(adr_q)
);

// File: tb/lpc_io_master_test.sv
module lpc_io_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq, lframe_n, lad_oe;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in = 4'hF;

  always #10 clk = ~clk;

  lpc_io_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .lad_in(lad_in)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Peripheral model configuration: response 0 ready, 1 error, 2 silent
  int p_wait = 0;
  int p_resp = 0;
  logic [7:0] p_rdata [64];

  // Peripheral model state and frame log
  int active = 0, k = 0, sync_k = 0, n_frames = 0, ri = 0;
  logic [3:0]  ct_nib, wlo, st_nib;
  logic [15:0] adr_acc;
  logic [3:0]  log_st [64];
  logic [3:0]  log_ct [64];
  logic [15:0] log_adr [64];
  logic [7:0]  log_dat [64];

  always @(negedge clk) begin
    lad_in <= 4'hF;
    if (rst_n && !lframe_n) begin
      active = 1; k = 0; st_nib = lad_out;
    end else if (rst_n && active != 0) begin
      k = k + 1;
      if (k == 1) ct_nib = lad_out;
      if (k >= 2 && k <= 5) adr_acc = {adr_acc[11:0], lad_out};
      if (k == 5) begin
        log_st[n_frames % 64]  = st_nib;
        log_ct[n_frames % 64]  = ct_nib;
        log_adr[n_frames % 64] = adr_acc;
        n_frames = n_frames + 1;
      end
      if (ct_nib == 4'h2) begin
        if (k == 6) wlo = lad_out;
        if (k == 7) log_dat[(n_frames - 1) % 64] = {lad_out, wlo};
        sync_k = 10;
      end else begin
        sync_k = 8;
      end
      if (k >= sync_k) begin
        if (k - sync_k < p_wait) begin
          lad_in <= ((k - sync_k) % 2 == 0) ? 4'h5 : 4'h6;
        end else if (k - sync_k == p_wait) begin
          lad_in <= (p_resp == 0) ? 4'h0 : (p_resp == 1) ? 4'hA : 4'hF;
        end else if (ct_nib == 4'h0 && p_resp == 0 && k - sync_k == p_wait + 1) begin
          lad_in <= p_rdata[ri % 64][3:0];
        end else if (ct_nib == 4'h0 && p_resp == 0 && k - sync_k == p_wait + 2) begin
          lad_in <= p_rdata[ri % 64][7:4];
          ri = ri + 1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    check({req, " irq raised"}, {31'd0, seen}, 32'd1);
  endtask

  task automatic clear_irq();
    wr_reg(8'h08, 32'h2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq pin", {31'd0, irq}, 32'd0);
    check("R1 lframe_n", {31'd0, lframe_n}, 32'd1);
    check("R1 lad_oe", {31'd0, lad_oe}, 32'd0);
    rd_reg(8'h04, d); check("R1 status", d, 32'd1);
    rd_reg(8'h08, d); check("R1 int reg", d, 32'd0);
  endtask

  task automatic t_write_inc();
    logic [31:0] d;
    int base = n_frames;
    p_wait = 0; p_resp = 0;
    wr_reg(8'h14, 32'h1);
    wr_reg(8'h24, 32'hAA); wr_reg(8'h24, 32'h55); wr_reg(8'h24, 32'hC3);
    wr_reg(8'h10, 32'd3);
    wr_reg(8'h20, 32'h02F8);
    wr_reg(8'h00, 32'h1);
    wait_irq("R6 write");
    check("R2 frame count", n_frames - base, 3);
    check("R2 start nibble", {28'd0, log_st[base % 64]}, 32'h0);
    check("R2 dir nibble", {28'd0, log_ct[base % 64]}, 32'h2);
    check("R5 addr0", {16'd0, log_adr[base % 64]}, 32'h02F8);
    check("R5 addr1", {16'd0, log_adr[(base + 1) % 64]}, 32'h02F9);
    check("R5 addr2", {16'd0, log_adr[(base + 2) % 64]}, 32'h02FA);
    check("R2 data0", {24'd0, log_dat[base % 64]}, 32'hAA);
    check("R2 data1", {24'd0, log_dat[(base + 1) % 64]}, 32'h55);
    check("R2 data2", {24'd0, log_dat[(base + 2) % 64]}, 32'hC3);
    rd_reg(8'h04, d); check("R6 status ok", d, 32'd3);
    rd_reg(8'h08, d); check("R6 int bit", d, 32'd2);
    clear_irq();
    rd_reg(8'h08, d); check("R6 w1c", d, 32'd0);
    check("R6 irq pin low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_read_fixed();
    logic [31:0] d;
    int base = n_frames;
    p_wait = 3; p_resp = 0;
    p_rdata[ri % 64] = 8'h3C; p_rdata[(ri + 1) % 64] = 8'hA7;
    wr_reg(8'h14, 32'h8);
    wr_reg(8'h10, 32'd2);
    wr_reg(8'h20, 32'h0060);
    wr_reg(8'h00, 32'h1);
    wait_irq("R4 read with waits");
    check("R3 frame count", n_frames - base, 2);
    check("R3 dir nibble", {28'd0, log_ct[base % 64]}, 32'h0);
    check("R5 fixed addr0", {16'd0, log_adr[base % 64]}, 32'h0060);
    check("R5 fixed addr1", {16'd0, log_adr[(base + 1) % 64]}, 32'h0060);
    rd_reg(8'h04, d); check("R4 status ok", d, 32'd3);
    rd_reg(8'h28, d); check("R3 byte0", d, 32'h3C);
    rd_reg(8'h28, d); check("R3 byte1", d, 32'hA7);
    rd_reg(8'h28, d); check("R3 empty", d, 32'h0);
    clear_irq();
  endtask

  task automatic t_sync_error();
    logic [31:0] d;
    int base = n_frames;
    p_wait = 1; p_resp = 1;
    wr_reg(8'h14, 32'h1);
    wr_reg(8'h24, 32'h11); wr_reg(8'h24, 32'h22); wr_reg(8'h24, 32'h33);
    wr_reg(8'h10, 32'd3);
    wr_reg(8'h20, 32'h0080);
    wr_reg(8'h00, 32'h1);
    wait_irq("R7 error");
    repeat (30) @(negedge clk);
    check("R7 one frame", n_frames - base, 1);
    rd_reg(8'h04, d); check("R7 status fail", d, 32'd1);
    clear_irq();
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    int base = n_frames;
    p_wait = 0; p_resp = 2;
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h10, 32'd2);
    wr_reg(8'h20, 32'h0070);
    wr_reg(8'h00, 32'h1);
    wait_irq("R8 timeout");
    repeat (30) @(negedge clk);
    check("R8 one frame", n_frames - base, 1);
    rd_reg(8'h04, d); check("R8 status fail", d, 32'd1);
    clear_irq();
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int base = n_frames;
    p_wait = 5; p_resp = 0;
    wr_reg(8'h14, 32'h1);
    wr_reg(8'h24, 32'h5A); wr_reg(8'h24, 32'hA5);
    wr_reg(8'h10, 32'd2);
    wr_reg(8'h20, 32'h0100);
    wr_reg(8'h00, 32'h1);
    rd_reg(8'h04, d); check("R12 busy status", d, 32'd0);
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h10, 32'd7);
    wr_reg(8'h20, 32'h1234);
    wr_reg(8'h24, 32'h99);
    wr_reg(8'h00, 32'h1);
    wait_irq("R9 busy run");
    repeat (40) @(negedge clk);
    check("R9 frame count", n_frames - base, 2);
    check("R9 data0", {24'd0, log_dat[base % 64]}, 32'h5A);
    check("R9 data1", {24'd0, log_dat[(base + 1) % 64]}, 32'hA5);
    check("R9 addr1", {16'd0, log_adr[(base + 1) % 64]}, 32'h0101);
    rd_reg(8'h14, d); check("R9 cmd kept", d, 32'h1);
    rd_reg(8'h10, d); check("R9 len kept", d, 32'd2);
    rd_reg(8'h20, d); check("R9 addr kept", d, 32'h0100);
    clear_irq();
  endtask

  task automatic t_len_zero();
    logic [31:0] d;
    int base = n_frames;
    wr_reg(8'h10, 32'd0);
    wr_reg(8'h00, 32'h1);
    repeat (50) @(negedge clk);
    check("R10 no frame", n_frames - base, 0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    rd_reg(8'h04, d); check("R10 status kept", d, 32'd3);
  endtask

  task automatic t_bad_kind();
    logic [31:0] d;
    int base = n_frames;
    wr_reg(8'h14, 32'h3);
    wr_reg(8'h10, 32'd1);
    wr_reg(8'h00, 32'h1);
    wait_irq("R11 kind");
    repeat (30) @(negedge clk);
    check("R11 no frame", n_frames - base, 0);
    rd_reg(8'h04, d); check("R11 status fail", d, 32'd1);
    clear_irq();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_inc();
    t_read_fixed();
    t_sync_error();
    t_timeout();
    t_busy_ignore();
    t_len_zero();
    t_bad_kind();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

endmodule